// File: doc/BRIEF.md
# Priority Assertion ID Trace Encoder

This block sits between a bank of hardware assertion checkers and a narrow debug trace port. Each checker raises a fire bit in the cycle it sees a violation. The trace port carries only a few bits per cycle, far fewer than there are checkers. So every cycle the encoder keeps one firing checker and reports its numeric identifier on the trace field. Code zero stands for an idle cycle.

A per-checker enable vector masks fire bits before selection. Engineers can therefore silence noisy checkers without changing the trace format. When several enabled checkers fire in the same cycle, the lowest-numbered one wins and the rest are lost for that cycle. A saturating counter records how many cycles lost at least one report. The trace word, its valid flag and the counter are all registered, one clock after the fire inputs.

Top module: `ae_trace_enc`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `trace_id_o`, `trace_vld_o` and `drop_cnt_o` are all zero.
- R2: If only the enabled checker at index i fires in a cycle, `trace_id_o` equals i+1 in the next cycle.
- R3: If several enabled checkers fire in one cycle, the next cycle reports the lowest index among them plus one.
- R4: If no enabled checker fires in a cycle, `trace_id_o` is 0 in the next cycle.
- R5: A fire bit whose `enable_i` bit is 0 has no effect on `trace_id_o`, `trace_vld_o` or `drop_cnt_o`.
- R6: Every output reflects only the inputs sampled at the previous rising edge (one cycle of latency). An idle cycle after a report returns the ID to 0.
- R7: Bits of `trace_id_o` at and above position ID_W = clog2(NUM_CHK+1) are always 0. With the defaults (20 checkers, 8-bit field), bits 7..5 are 0.
- R8: `drop_cnt_o` rises by one in the cycle after any cycle in which two or more enabled checkers fire. It is otherwise unchanged, and it holds at its all-ones value (15 by default) once it gets there.
- R9: `trace_vld_o` is 1 exactly when `trace_id_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | NUM_CHK | Per-checker violation strobes, bit i is checker index i |
| enable_i | input | NUM_CHK | Per-checker enable mask, 1 lets the fire bit through |
| trace_id_o | output | TRACE_W | Registered ID of the reported checker, 0 when idle |
| trace_vld_o | output | 1 | High when `trace_id_o` carries a report |
| drop_cnt_o | output | CNT_W | Saturating count of cycles with unreported violations |

## Verification
The bench drives every checker index alone, so an off-by-one in the numbering or a reversed priority shows up as a wrong ID. It drives pairs, including a masked low index next to an enabled higher one. A design that masked after selection, or that picked the highest index, would report the wrong checker or report nothing. Back-to-back fire and idle cycles expose a design whose output holds the last report or has the wrong latency. A long run of multi-fire cycles drives the drop counter past its limit, so a counter that wraps instead of saturating returns a small value.

// File: rtl/ae_trace_pkg.sv
package ae_trace_pkg;

  // Identifier reserved for a cycle with no report
  localparam int unsigned ID_IDLE = 0;

  // Bits needed to code identifiers 0..n (checker n-1 maps to n)
  function automatic int unsigned id_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((2 ** b) < (n + 1)) b++;
    return b;
  endfunction

endpackage

// File: rtl/ae_fire_gate.sv
module ae_fire_gate #(
  parameter int unsigned NUM_CHK = 20
) (
  input  logic [NUM_CHK-1:0] fire_i,
  input  logic [NUM_CHK-1:0] enable_i,
  output logic [NUM_CHK-1:0] live_o,
  output logic               any_o,
  output logic               multi_o
);

  logic [NUM_CHK-1:0] live;
  logic [NUM_CHK-1:0] rest;

  assign live = fire_i & enable_i;
  // Clearing the lowest set bit leaves something only if two or more bits were set
  assign rest = live & (live - NUM_CHK'(1));

  assign live_o  = live;
  assign any_o   = |live;
  assign multi_o = |rest;

endmodule

// File: rtl/ae_prio_pick.sv
module ae_prio_pick #(
  parameter int unsigned NUM_CHK = 20,
  parameter int unsigned ID_W    = 5
) (
  input  logic [NUM_CHK-1:0] live_i,
  output logic [ID_W-1:0]    id_o
);

  // Scan from the top so the lowest set index is written last and wins
  always_comb begin
    id_o = ID_W'(ae_trace_pkg::ID_IDLE);
    for (int i = NUM_CHK - 1; i >= 0; i--) begin
      if (live_i[i]) id_o = ID_W'(i + 1);
    end
  end

endmodule

// File: rtl/ae_sat_count.sv
module ae_sat_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_TOP)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ae_trace_enc.sv
module ae_trace_enc #(
  parameter int unsigned NUM_CHK = 20,
  parameter int unsigned TRACE_W = 8,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CHK-1:0] fire_i,
  input  logic [NUM_CHK-1:0] enable_i,
  output logic [TRACE_W-1:0] trace_id_o,
  output logic               trace_vld_o,
  output logic [CNT_W-1:0]   drop_cnt_o
);

  localparam int unsigned ID_W = ae_trace_pkg::id_bits(NUM_CHK);

  generate
    if (ID_W > TRACE_W) begin : g_too_many
      $error("ae_trace_enc: NUM_CHK needs more identifier bits than TRACE_W");
    end
  endgenerate

  logic [NUM_CHK-1:0] live;
  logic               any_live;
  logic               multi_live;
  logic [ID_W-1:0]    pick_id;
  logic [TRACE_W-1:0] id_q;
  logic               vld_q;

  ae_fire_gate #(.NUM_CHK(NUM_CHK)) u_gate (
    .fire_i   (fire_i),
    .enable_i (enable_i),
    .live_o   (live),
    .any_o    (any_live),
    .multi_o  (multi_live)
  );

  ae_prio_pick #(.NUM_CHK(NUM_CHK), .ID_W(ID_W)) u_pick (
    .live_i (live),
    .id_o   (pick_id)
  );

  ae_sat_count #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst   (rst),
    .inc_i (multi_live),
    .cnt_o (drop_cnt_o)
  );

  // Unused upper trace bits come out as zero through the width extension
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      id_q  <= TRACE_W'(pick_id);
      vld_q <= any_live;
    end
  end

  assign trace_id_o  = id_q;
  assign trace_vld_o = vld_q;

endmodule

// File: rtl/ae_trace_enc_chk.sv
module ae_trace_enc_chk #(
  parameter int unsigned NUM_CHK = 20,
  parameter int unsigned TRACE_W = 8,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CHK-1:0] fire_i,
  input logic [NUM_CHK-1:0] enable_i,
  input logic [TRACE_W-1:0] trace_id_o,
  input logic               trace_vld_o,
  input logic [CNT_W-1:0]   drop_cnt_o
);

  localparam int unsigned ID_W = ae_trace_pkg::id_bits(NUM_CHK);

  logic [NUM_CHK-1:0] act;
  assign act = fire_i & enable_i;

  // R9
  vld_matches_id_chk: assert property (@(posedge clk) disable iff (rst)
    trace_vld_o == (trace_id_o != '0));

  // R7
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (trace_id_o >> ID_W) == '0);

  // R4
  idle_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |=> (trace_id_o == '0));

  // R2
  any_fire_reports_chk: assert property (@(posedge clk) disable iff (rst)
    (act != '0) |=> trace_vld_o);

  // R3
  index0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    act[0] |=> (trace_id_o == TRACE_W'(1)));

  // R8
  drop_never_falls_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));

  // R8
  single_keeps_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(act) < 2) |=> $stable(drop_cnt_o));

endmodule

bind ae_trace_enc ae_trace_enc_chk #(
  .NUM_CHK(NUM_CHK), .TRACE_W(TRACE_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fire_i      (fire_i),
  .enable_i    (enable_i),
  .trace_id_o  (trace_id_o),
  .trace_vld_o (trace_vld_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/sim_ae_trace_enc.sv
`timescale 1ns/1ps
module sim_ae_trace_enc;

  localparam int N  = 20;
  localparam int TW = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  fire = '0;
  logic [N-1:0]  en   = '0;
  logic [TW-1:0] id;
  logic          vld;
  logic [CW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  ae_trace_enc #(.NUM_CHK(N), .TRACE_W(TW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .fire_i(fire), .enable_i(en),
    .trace_id_o(id), .trace_vld_o(vld), .drop_cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then check the registered result after the edge
  task automatic step(input logic [N-1:0] f, input logic [N-1:0] e, input string req);
    int exp_id;
    int n;
    logic [N-1:0] a;
    @(negedge clk);
    fire = f;
    en   = e;
    a = f & e;
    exp_id = 0;
    n = 0;
    for (int i = N - 1; i >= 0; i--) if (a[i]) begin exp_id = i + 1; n++; end
    if (n > 1 && exp_cnt < CMAX) exp_cnt++;
    @(posedge clk);
    #1;
    chk(id == TW'(exp_id), req, int'(id), exp_id);
    chk(vld == (exp_id != 0), "R9", int'(vld), int'(exp_id != 0));
    chk(cnt == CW'(exp_cnt), "R8", int'(cnt), exp_cnt);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    fire = '1;
    en = '1;
    repeat (3) @(posedge clk);
    #1;
    chk(id == '0 && !vld && cnt == '0, "R1 in reset", int'(id), 0);
    @(negedge clk);
    rst = 1'b0;
    fire = '0;
    #1;
    chk(id == '0 && !vld && cnt == '0, "R1 after release", int'(id), 0);
    exp_cnt = 0;
  endtask

  task automatic t_single;
    for (int i = 0; i < N; i++) step(N'(1) << i, '1, "R2 single");
  endtask

  task automatic t_multi;
    step(N'(1) << 3 | N'(1) << 7, '1, "R3 pair 3,7");
    step(N'(1) << 19 | N'(1) << 12, '1, "R3 pair 12,19");
    step('1, '1, "R3 all fire");
    step(N'(1) | N'(1) << 19, '1, "R3 ends");
  endtask

  task automatic t_mask;
    step(N'(1) << 5, ~(N'(1) << 5), "R5 masked single");
    step(N'(1) << 2 | N'(1) << 9, ~(N'(1) << 2), "R5 masked low");
    step('1, '0, "R5 all masked");
  endtask

  task automatic t_idle_latency;
    step(N'(1) << 10, '1, "R6 report");
    step('0, '1, "R4 idle after report");
    step('0, '0, "R4 idle");
    step(N'(1) << 4, '1, "R6 back to back a");
    step(N'(1) << 6, '1, "R6 back to back b");
  endtask

  task automatic t_upper;
    step(N'(1) << (N - 1), '1, "R7 top index");
    chk((id >> 5) == '0, "R7 upper bits", int'(id >> 5), 0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < CMAX + 4; k++) step(N'(3) << (k % 10), '1, "R8 multi");
    chk(cnt == CW'(CMAX), "R8 saturated", int'(cnt), CMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_mask();
    t_idle_latency();
    t_upper();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule